// File: doc/BRIEF.md
# Multidrop Nine-Bit Receive Address Filter

This block is the receive side of a node on a shared serial line where many receivers listen to one sender. Every character on the wire carries eight data bits plus a ninth qualifier bit in the slot a parity bit would use. A qualifier of 1 marks an address character and a qualifier of 0 marks a data character. The block samples the line with a 16x oversampling tick. It decides whether the node has been addressed and forwards only the data meant for this node into a small receive FIFO.

Each address character is compared against a programmed node address under a programmable mask. A match selects the node and raises a match interrupt, which has its own enable. A miss deselects the node, and every data character after it is discarded until the next matching address. Framing errors and FIFO overruns are reported through sticky flags that are cleared by writing one.

Receiver FSM states: `RX_IDLE` (line high; goes to `RX_START` on a low sample), `RX_START` (confirms the start bit at mid-bit; goes back to `RX_IDLE` on a glitch, otherwise to `RX_DATA`), `RX_DATA` (eight bits, LSB first, then `RX_QUAL`), `RX_QUAL` (ninth bit, then `RX_STOP`), `RX_STOP` (samples the stop bit; goes to `RX_IDLE` if it is high, to `RX_HOLD` if it is low), and `RX_HOLD` (waits for the line to return high, then `RX_IDLE`). Node FSM states: `NODE_OFF` and `NODE_ON`. Any good address character moves the node to `NODE_ON` on a match and to `NODE_OFF` on a miss. Data characters and bad frames leave the node state unchanged.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset the node is deselected, irq, frame_err and overrun are 0, the FIFO is empty, the node address is 0x00 and the mask is 0xFF.
- R2: A character is a low start bit, eight data bits LSB first, the qualifier bit and a high stop bit, each 16 baud_tick periods long. The start bit is confirmed by a low sample 8 ticks after the falling edge is seen.
- R3: An address character matches when it equals the node address on every bit where the mask is 1. Bits where the mask is 0 are ignored. cfg_we loads both the address and the mask.
- R4: A matching address character selects the node. That address character is not stored. Data characters that follow are pushed into the FIFO in arrival order.
- R5: A non-matching address character deselects the node. The address character and all data characters after it are discarded.
- R6: Each match sets a pending bit, and irq equals pending AND irq_en. Writing ack_w1c[0]=1 clears pending unless a match arrives in the same cycle.
- R7: A character whose stop bit is low is discarded and sets frame_err. The node state is unchanged. frame_err stays set until ack_w1c[1]=1.
- R8: A data character for a selected node that finds the FIFO full is dropped and sets overrun. The FIFO contents are unchanged. overrun stays set until ack_w1c[2]=1.
- R9: No parity check is done. A good-stop character with either qualifier value never sets frame_err.
- R10: rd_data shows the oldest stored byte while rd_empty is 0. rd_en pops one byte, and rd_en while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| cfg_we | input | 1 | Loads cfg_node_addr and cfg_node_mask |
| cfg_node_addr | input | 8 | Node address to load |
| cfg_node_mask | input | 8 | Compare mask to load, 1 = compare this bit |
| irq_en | input | 1 | Match interrupt enable |
| ack_w1c | input | 3 | Write-one-to-clear: [0] pending match, [1] frame_err, [2] overrun |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| rd_empty | output | 1 | FIFO holds no byte |
| selected | output | 1 | Node is addressed |
| irq | output | 1 | Match interrupt level |
| frame_err | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky FIFO overrun |

## Verification
A wrong node state shows up at the ports as soon as the next data character ends. Bytes appear in or vanish from the FIFO, and `selected` differs from the model within a few cycles of the address stop bit. A wrong bit counter or sampling phase corrupts the byte popped from rd_data, or it raises frame_err on a clean frame. Flag and pending-bit errors show on irq, frame_err or overrun, which the bench compares against its model on every clock between characters.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_QUAL,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic {
        NODE_OFF,
        NODE_ON
    } node_state_e;

endpackage

// File: rtl/mdrx_bitrx.sv
module mdrx_bitrx #(
    parameter int OSR   = 16,
    parameter int DBITS = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_in,
    output logic             chr_valid,
    output logic [DBITS-1:0] chr_data,
    output logic             chr_qual,
    output logic             chr_stop_ok
);
    import mdrx_pkg::*;

    localparam int CW   = $clog2(OSR);
    localparam int IW   = $clog2(DBITS);
    localparam int HALF = OSR / 2 - 1;

    logic [SYNC-1:0] sync_q;
    logic            rx;

    genvar g;
    generate
        for (g = 0; g < SYNC; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign rx = sync_q[SYNC-1];

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    idx_q;
    logic [DBITS-1:0] shf_q;
    logic             bit_end;
    logic             mid_start;

    assign bit_end   = tick && (cnt_q == CW'(OSR - 1));
    assign mid_start = tick && (cnt_q == CW'(HALF));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !rx) state_d = RX_START;
            RX_START: if (mid_start) state_d = rx ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && idx_q == IW'(DBITS - 1)) state_d = RX_QUAL;
            RX_QUAL:  if (bit_end) state_d = RX_STOP;
            RX_STOP:  if (bit_end) state_d = rx ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rx) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            shf_q       <= '0;
            chr_valid   <= 1'b0;
            chr_data    <= '0;
            chr_qual    <= 1'b0;
            chr_stop_ok <= 1'b0;
        end else begin
            chr_valid <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                RX_START: begin
                    if (mid_start)  cnt_q <= '0;
                    else if (tick)  cnt_q <= cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (bit_end) begin
                        cnt_q <= '0;
                        shf_q <= {rx, shf_q[DBITS-1:1]};
                        idx_q <= idx_q + 1'b1;
                    end
                end
                RX_QUAL: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (bit_end) begin
                        cnt_q    <= '0;
                        chr_qual <= rx;
                    end
                end
                RX_STOP: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (bit_end) begin
                        cnt_q       <= '0;
                        chr_valid   <= 1'b1;
                        chr_data    <= shf_q;
                        chr_stop_ok <= rx;
                    end
                end
                RX_HOLD: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/mdrx_select.sv
module mdrx_select #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chr_valid,
    input  logic [W-1:0] chr_data,
    input  logic         chr_qual,
    input  logic         chr_stop_ok,
    input  logic [W-1:0] node_addr,
    input  logic [W-1:0] node_mask,
    input  logic         fifo_full,
    output logic         sel,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         match_hit,
    output logic         ferr_set,
    output logic         ovr_set
);
    import mdrx_pkg::*;

    node_state_e state_q, state_d;
    logic        good, is_addr, is_data, hit;

    assign good    = chr_valid && chr_stop_ok;
    assign is_addr = good && chr_qual;
    assign is_data = good && !chr_qual;
    assign hit     = ((chr_data ^ node_addr) & node_mask) == '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NODE_OFF: if (is_addr && hit)  state_d = NODE_ON;
            NODE_ON:  if (is_addr && !hit) state_d = NODE_OFF;
            default:  state_d = NODE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NODE_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_data <= '0;
            match_hit <= 1'b0;
            ferr_set  <= 1'b0;
            ovr_set   <= 1'b0;
        end else begin
            push      <= 1'b0;
            match_hit <= 1'b0;
            ferr_set  <= chr_valid && !chr_stop_ok;
            ovr_set   <= 1'b0;
            unique case (state_q)
                NODE_OFF: begin
                    if (is_addr && hit) match_hit <= 1'b1;
                end
                NODE_ON: begin
                    if (is_addr && hit) match_hit <= 1'b1;
                    if (is_data) begin
                        push_data <= chr_data;
                        if (fifo_full) ovr_set <= 1'b1;
                        else           push    <= 1'b1;
                    end
                end
                default: push <= 1'b0;
            endcase
        end
    end

    assign sel = (state_q == NODE_ON);

endmodule

// File: rtl/mdrx_fifo.sv
module mdrx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr_q, rptr_q;
    logic         do_push, do_pop;

    assign empty   = (wptr_q == rptr_q);
    assign full    = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr_q[AW-1:0]];
    assign level   = wptr_q - rptr_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter #(
    parameter int W          = 8,
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int SYNC       = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         rxd,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_node_addr,
    input  logic [W-1:0] cfg_node_mask,
    input  logic         irq_en,
    input  logic [2:0]   ack_w1c,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_empty,
    output logic         selected,
    output logic         irq,
    output logic         frame_err,
    output logic         overrun
);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic         chr_valid, chr_qual, chr_stop_ok;
    logic [W-1:0] chr_data;
    logic [W-1:0] addr_q, mask_q;
    logic         push, match_hit, ferr_set, ovr_set, fifo_full;
    logic [W-1:0] push_data;
    logic [AW:0]  fifo_level;
    logic         pend_q, ferr_q, ovr_q;

    mdrx_bitrx #(.OSR(OSR), .DBITS(W), .SYNC(SYNC)) u_bitrx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .line_in     (rxd),
        .chr_valid   (chr_valid),
        .chr_data    (chr_data),
        .chr_qual    (chr_qual),
        .chr_stop_ok (chr_stop_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '1;
        end else if (cfg_we) begin
            addr_q <= cfg_node_addr;
            mask_q <= cfg_node_mask;
        end
    end

    mdrx_select #(.W(W)) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .chr_valid   (chr_valid),
        .chr_data    (chr_data),
        .chr_qual    (chr_qual),
        .chr_stop_ok (chr_stop_ok),
        .node_addr   (addr_q),
        .node_mask   (mask_q),
        .fifo_full   (fifo_full),
        .sel         (selected),
        .push        (push),
        .push_data   (push_data),
        .match_hit   (match_hit),
        .ferr_set    (ferr_set),
        .ovr_set     (ovr_set)
    );

    mdrx_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_data),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (rd_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (match_hit)       pend_q <= 1'b1;
            else if (ack_w1c[0]) pend_q <= 1'b0;
            if (ferr_set)        ferr_q <= 1'b1;
            else if (ack_w1c[1]) ferr_q <= 1'b0;
            if (ovr_set)         ovr_q  <= 1'b1;
            else if (ack_w1c[2]) ovr_q  <= 1'b0;
        end
    end

    assign irq       = pend_q && irq_en;
    assign frame_err = ferr_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/mdrx_chk.sv
module mdrx_chk #(
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          pend,
    input logic          match_hit,
    input logic          ferr,
    input logic          ovr,
    input logic [2:0]    ack,
    input logic [LW-1:0] level,
    input logic          empty,
    input logic          full
);

    a_r4_fill_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> $past(sel));

    a_r6_pending_implies_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> sel);

    a_r6_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !match_hit) |=> !pend);

    a_r7_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !ack[1]) |=> ferr);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ack[2]) |=> ovr);

    a_r10_empty_full_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

endmodule

bind mdrop_rx_filter mdrx_chk #(.LW(AW + 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (selected),
    .pend      (pend_q),
    .match_hit (match_hit),
    .ferr      (ferr_q),
    .ovr       (ovr_q),
    .ack       (ack_w1c),
    .level     (fifo_level),
    .empty     (rd_empty),
    .full      (fifo_full)
);

// File: tb/mdrop_rx_filter_bench.sv
module mdrop_rx_filter_bench;
    localparam int DEPTH  = 4;
    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_node_addr = '0;
    logic [7:0] cfg_node_mask = '0;
    logic       irq_en = 1'b0;
    logic [2:0] ack_w1c = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_empty, selected, irq, frame_err, overrun;

    always #2 clk = ~clk;

    always @(negedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

    mdrop_rx_filter #(.FIFO_DEPTH(DEPTH)) u_mdrop_rx_filter (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_we(cfg_we), .cfg_node_addr(cfg_node_addr), .cfg_node_mask(cfg_node_mask),
        .irq_en(irq_en), .ack_w1c(ack_w1c), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .selected(selected), .irq(irq),
        .frame_err(frame_err), .overrun(overrun)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] m_q[$];
    logic [7:0] m_addr = 8'h00;
    logic [7:0] m_mask = 8'hFF;
    bit m_sel = 0, m_pend = 0, m_ferr = 0, m_ovr = 0;
    bit chk_on = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(selected == m_sel, "R4 selected", selected, m_sel);
            check(irq == (m_pend && irq_en), "R6 irq", irq, m_pend && irq_en);
            check(frame_err == m_ferr, "R7 frame_err", frame_err, m_ferr);
            check(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
            check(rd_empty == (m_q.size() == 0), "R10 empty", rd_empty, m_q.size() == 0);
            if (m_q.size() != 0)
                check(rd_data == m_q[0], "R10 head", rd_data, m_q[0]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit qual, input bit stop_ok);
        bit match;
        chk_on = 0;
        @(negedge clk);
        rxd = 1'b0;
        idle(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            idle(BITCLK);
        end
        rxd = qual;
        idle(BITCLK);
        rxd = stop_ok;
        idle(BITCLK);
        rxd = 1'b1;
        idle(BITCLK + 8);
        if (!stop_ok) m_ferr = 1;
        else if (qual) begin
            match = 1;
            for (int i = 0; i < 8; i++)
                if (m_mask[i] && (b[i] != m_addr[i])) match = 0;
            m_sel = match;
            if (match) m_pend = 1;
        end else if (m_sel) begin
            if (m_q.size() < DEPTH) m_q.push_back(b);
            else m_ovr = 1;
        end
        chk_on = 1;
        idle(4);
    endtask

    task automatic ack(input logic [2:0] v);
        chk_on = 0;
        @(negedge clk);
        ack_w1c = v;
        @(negedge clk);
        ack_w1c = '0;
        if (v[0]) m_pend = 0;
        if (v[1]) m_ferr = 0;
        if (v[2]) m_ovr = 0;
        idle(2);
        chk_on = 1;
        idle(2);
    endtask

    task automatic pop(input string tag);
        chk_on = 0;
        @(negedge clk);
        if (m_q.size() != 0)
            check(rd_data == m_q[0], tag, rd_data, m_q[0]);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (m_q.size() != 0) void'(m_q.pop_front());
        idle(2);
        chk_on = 1;
        idle(2);
    endtask

    task automatic program_node(input logic [7:0] a, input logic [7:0] m);
        chk_on = 0;
        @(negedge clk);
        cfg_node_addr = a;
        cfg_node_mask = m;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_addr = a;
        m_mask = m;
        chk_on = 1;
        idle(2);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        check(selected == 0, "R1 selected", selected, 0);
        check(irq == 0, "R1 irq", irq, 0);
        check(frame_err == 0 && overrun == 0, "R1 flags", {frame_err, overrun}, 0);
        check(rd_empty == 1, "R1 empty", rd_empty, 1);
        chk_on = 1;

        // R3 default exact match on 0x00; a near miss must not select
        send(8'h01, 1, 1);
        check(selected == 0, "R3 default mask exact", selected, 0);
        send(8'h33, 0, 1);
        check(rd_empty == 1, "R5 data dropped while deselected", rd_empty, 1);
        send(8'h00, 1, 1);
        check(selected == 1, "R3 default address match", selected, 1);
        check(irq == 0, "R6 irq masked", irq, 0);
        check(rd_empty == 1, "R4 address not stored", rd_empty, 1);
        irq_en = 1'b1;
        idle(2);
        check(irq == 1, "R6 irq enabled", irq, 1);
        ack(3'b001);
        check(irq == 0, "R6 ack clears", irq, 0);

        // R2 bit order, R9 no parity error on data frames
        send(8'h5A, 0, 1);
        send(8'hA5, 0, 1);
        send(8'h80, 0, 1);
        check(frame_err == 0, "R9 no parity error", frame_err, 0);
        pop("R2 byte 5A");
        pop("R2 byte A5");
        pop("R4 order 80");
        check(rd_empty == 1, "R10 drained", rd_empty, 1);
        pop("R10 pop on empty");
        check(rd_empty == 1, "R10 empty pop no effect", rd_empty, 1);

        // R3 masked compare
        program_node(8'h3C, 8'hF0);
        send(8'h35, 1, 1);
        check(selected == 1, "R3 masked match", selected, 1);
        send(8'h11, 0, 1);
        send(8'h4C, 1, 1);
        check(selected == 0, "R5 miss deselects", selected, 0);
        send(8'h22, 0, 1);
        check(m_q.size() == 1, "R5 model one byte", m_q.size(), 1);
        pop("R4 byte 11");
        check(rd_empty == 1, "R5 byte after miss dropped", rd_empty, 1);

        // R7 bad stop keeps node state, then later frames still work
        send(8'h3F, 1, 1);
        check(selected == 1, "R3 masked low bits ignored", selected, 1);
        send(8'h77, 0, 0);
        check(frame_err == 1, "R7 framing error", frame_err, 1);
        check(selected == 1, "R7 state kept", selected, 1);
        check(rd_empty == 1, "R7 frame discarded", rd_empty, 1);
        send(8'h99, 0, 1);
        check(frame_err == 1, "R7 sticky", frame_err, 1);
        ack(3'b010);
        check(frame_err == 0, "R7 cleared", frame_err, 0);

        // R8 overrun
        for (int i = 0; i < DEPTH; i++) send(8'hC0 + 8'(i), 0, 1);
        check(overrun == 1, "R8 overrun on full", overrun, 1);
        ack(3'b100);
        check(overrun == 0, "R8 cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) pop("R8 contents kept");
        check(rd_empty == 1, "R10 empty after drain", rd_empty, 1);

        chk_on = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule